// File: doc/BRIEF.md
# Load/Store Port Request Sequencer

This block is the requesting side of a handshaked memory port. It takes one load or store command at a time: direction, address, store data, byte count, a zero-block flag and a problem-state bit. It raises the port request lines and then steps through the port handshake. That handshake consists of address acceptance, then either a one-clock store-data strobe or a wait for returned load data, and finally a wait for the port's busy signal to clear.

At fixed points along the way the sequencer reads the port's exception record. Bit 0 of that record is the "exception happened" flag. An exception seen while the address is pending, or just after the store strobe, is classed as early (fast). An exception seen at load-data return, or once busy has fallen, is classed as late (slow).

When the transaction finishes, the block pulses a done flag for one clock. Along with it, it presents a two-bit outcome, the captured exception record, and the load data. Load data is zero whenever an exception is reported. The memory system behind the port lies outside this block.

Top module: `ldst_port_seq`

## Requirements
- R1: After reset the block is idle: `cmdReady` is high and every request line is low. `cmdReady` is high only while idle. When `cmdValid` and `cmdReady` are both high at a clock edge with a legal length, then from that edge onward the block drives all of these together: the direction request (`portStReq` for a store, `portLdReq` for a load), `portAddrValid`, `portAddr` and `portLen`.
- R2: The length field is a byte count, and only 1, 2, 4 and 8 are legal. A command with any other length raises no request line. It completes in the cycle after acceptance with status code 3.
- R3: While a request is raised, `portPriv` is the inverse of the accepted problem-state bit.
- R4: The address phase lasts until `portAddrOk` is high or `portExc[0]` is high at a clock edge. If `portExc[0]` is high, the exception takes priority, including in the first request cycle.
- R5: For a store, the clock after address acceptance drives `portStValid` high for exactly one cycle, with `portStData` equal to the command data. The exception record is sampled in the next cycle.
- R6: When an exception is seen during the address phase or just after the store strobe, the outcome is fast (code 1). The request, address-valid and zero-block lines stay high for one further clock, then drop as done pulses.
- R7: For a store, if the exception flag is high at the clock where `portBusy` is first seen low, the outcome is slow (code 2). Requests stay high one more clock, then drop, then one idle clock passes before done.
- R8: A store that ends with busy low and no exception drops its requests in the next cycle. One idle clock follows, then done with code 0.
- R9: For a load, after address acceptance the block waits one clock and then waits for `portLdOk`. At that edge it captures the load data and the exception record. If the flag is set there, the outcome is slow, and requests drop as done pulses.
- R10: After a clean load-data capture, the request lines drop at once. The block then waits for `portBusy` low. At that point it reports slow if the exception flag is set and code 0 otherwise.
- R11: `resDone` is a one-cycle pulse. `resStatus` is 0 for no exception, 1 for fast, 2 for slow and 3 for an illegal length. `resExc` is the record taken at the deciding check, or zero for code 3. `resLdData` is zero unless a load ends with code 0.
- R12: `portZeroBlk` follows the accepted zero-block flag while a request is raised and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Block idle, command taken |
| cmdIsStore | input | 1 | 1 = store, 0 = load |
| cmdAddr | input | ADDR_W | Access address |
| cmdData | input | DATA_W | Store data |
| cmdLen | input | 4 | Byte count |
| cmdZeroBlk | input | 1 | Zero-block store flag |
| cmdProbState | input | 1 | Problem-state bit |
| portLdReq | output | 1 | Load request |
| portStReq | output | 1 | Store request |
| portAddr | output | ADDR_W | Request address |
| portAddrValid | output | 1 | Address valid |
| portLen | output | 4 | Request byte count |
| portZeroBlk | output | 1 | Zero-block flag to port |
| portPriv | output | 1 | Privileged mode (inverse of problem state) |
| portStData | output | DATA_W | Store data |
| portStValid | output | 1 | Store data strobe |
| portAddrOk | input | 1 | Address accepted |
| portLdOk | input | 1 | Load data valid |
| portLdData | input | DATA_W | Load data |
| portBusy | input | 1 | Port still working |
| portExc | input | EXC_W | Exception record, bit 0 = happened |
| resDone | output | 1 | Completion pulse |
| resStatus | output | 2 | Outcome code |
| resLdData | output | DATA_W | Captured load data |
| resExc | output | EXC_W | Captured exception record |

## Verification
The assertions assume a well-behaved port:
- `portAddrOk` and `portLdOk` arrive only while a request is pending.
- `portBusy` is meaningful only after the store strobe or the load-data capture.
- The exception flag is raised only at a point where the sequencer actually checks it.

The stimulus keeps within these assumptions by scripting the responder cycle by cycle from the command's own phase. Each input is raised at the checkpoint it targets and cleared in the following cycle. A command is offered only once the previous done pulse has passed.

// File: rtl/ldst_seq_pkg.sv
package ldst_seq_pkg;

  localparam int LEN_W = 4;
  localparam int EXC_FLAG_BIT = 0;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_STROBE, S_STCHK, S_STBUSY,
    S_LDGAP, S_LDWAIT, S_LDBUSY, S_HOLD, S_GAP, S_DONE
  } seqState_e;

  typedef enum logic [1:0] {
    RES_NONE   = 2'd0,
    RES_FAST   = 2'd1,
    RES_SLOW   = 2'd2,
    RES_BADLEN = 2'd3
  } resCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchCmd;
    logic     capExc;
    logic     capData;
    logic     setStatus;
    resCode_e status;
  } dpCtl_t;

  function automatic logic lenLegal(input logic [LEN_W-1:0] len);
    return (len == 4'd1) || (len == 4'd2) || (len == 4'd4) || (len == 4'd8);
  endfunction

endpackage

// File: rtl/ldst_seq_ctrl.sv
module ldst_seq_ctrl
  import ldst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             isStore,
  input  logic             portAddrOk,
  input  logic             portLdOk,
  input  logic             portBusy,
  input  logic             excHappened,
  output logic             cmdReady,
  output logic             reqActive,
  output logic             stStrobe,
  output logic             resDone,
  output dpCtl_t           ctl
);

  seqState_e state, nextState;
  logic      slowTail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      slowTail <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState == S_HOLD) slowTail <= (state == S_STBUSY);
    end
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    ctl.status = RES_NONE;
    unique case (state)
      S_IDLE: begin
        if (cmdValid) begin
          ctl.latchCmd = 1'b1;
          if (lenLegal(cmdLen)) begin
            nextState = S_ADDR;
          end else begin
            ctl.setStatus = 1'b1;
            ctl.status    = RES_BADLEN;
            nextState     = S_DONE;
          end
        end
      end
      S_ADDR: begin
        if (excHappened) begin
          ctl.capExc    = 1'b1;
          ctl.setStatus = 1'b1;
          ctl.status    = RES_FAST;
          nextState     = S_HOLD;
        end else if (portAddrOk) begin
          nextState = isStore ? S_STROBE : S_LDGAP;
        end
      end
      S_STROBE: nextState = S_STCHK;
      S_STCHK: begin
        if (excHappened) begin
          ctl.capExc    = 1'b1;
          ctl.setStatus = 1'b1;
          ctl.status    = RES_FAST;
          nextState     = S_HOLD;
        end else begin
          nextState = S_STBUSY;
        end
      end
      S_STBUSY: begin
        if (!portBusy) begin
          ctl.capExc    = 1'b1;
          ctl.setStatus = 1'b1;
          ctl.status    = excHappened ? RES_SLOW : RES_NONE;
          nextState     = excHappened ? S_HOLD : S_GAP;
        end
      end
      S_LDGAP: nextState = S_LDWAIT;
      S_LDWAIT: begin
        if (portLdOk) begin
          ctl.capData = 1'b1;
          ctl.capExc  = 1'b1;
          if (excHappened) begin
            ctl.setStatus = 1'b1;
            ctl.status    = RES_SLOW;
            nextState     = S_DONE;
          end else begin
            nextState = S_LDBUSY;
          end
        end
      end
      S_LDBUSY: begin
        if (!portBusy) begin
          ctl.capExc    = 1'b1;
          ctl.setStatus = 1'b1;
          ctl.status    = excHappened ? RES_SLOW : RES_NONE;
          nextState     = S_DONE;
        end
      end
      S_HOLD:  nextState = slowTail ? S_GAP : S_DONE;
      S_GAP:   nextState = S_DONE;
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign cmdReady  = (state == S_IDLE);
  assign stStrobe  = (state == S_STROBE);
  assign resDone   = (state == S_DONE);
  assign reqActive = (state == S_ADDR)   || (state == S_STROBE) ||
                     (state == S_STCHK)  || (state == S_STBUSY) ||
                     (state == S_LDGAP)  || (state == S_LDWAIT) ||
                     (state == S_HOLD);

  p_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && lenLegal(cmdLen)) |=> reqActive);

  p_badlen_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && !lenLegal(cmdLen)) |=> (resDone && !reqActive));

  p_addr_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR && !excHappened && !portAddrOk) |=> (state == S_ADDR));

  p_strobe_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    stStrobe |=> !stStrobe);

  p_strobe_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    stStrobe |-> ($past(portAddrOk) && $past(reqActive)));

  p_fast_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_ADDR || state == S_STCHK) && excHappened) |=> reqActive);

  p_hold_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && !slowTail) |=> (!reqActive && resDone));

  p_slow_tail_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && slowTail) |=> (!reqActive && !resDone));

  p_store_clean_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STBUSY && !portBusy && !excHappened) |=> (!reqActive && !resDone));

  p_ld_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR && portAddrOk && !excHappened && !isStore) |=> (state == S_LDGAP));

  p_ld_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LDWAIT && portLdOk) |=> !reqActive);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    resDone |=> (!resDone && cmdReady));

endmodule

// File: rtl/ldst_seq_dp.sv
module ldst_seq_dp
  import ldst_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int EXC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              reqActive,
  input  logic              stStrobe,
  input  logic              resDone,
  input  logic              cmdIsStore,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              cmdZeroBlk,
  input  logic              cmdProbState,
  input  logic [DATA_W-1:0] portLdData,
  input  logic [EXC_W-1:0]  portExc,
  output logic              isStore,
  output logic              portLdReq,
  output logic              portStReq,
  output logic [ADDR_W-1:0] portAddr,
  output logic              portAddrValid,
  output logic [LEN_W-1:0]  portLen,
  output logic              portZeroBlk,
  output logic              portPriv,
  output logic [DATA_W-1:0] portStData,
  output logic              portStValid,
  output logic [1:0]        resStatus,
  output logic [DATA_W-1:0] resLdData,
  output logic [EXC_W-1:0]  resExc
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LEN_W-1:0]  lenQ;
  logic              zeroQ, probQ;
  resCode_e          statusQ;
  logic [DATA_W-1:0] ldDataQ;
  logic [EXC_W-1:0]  excQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      lenQ    <= '0;
      isStore <= 1'b0;
      zeroQ   <= 1'b0;
      probQ   <= 1'b0;
    end else if (ctl.latchCmd) begin
      addrQ   <= cmdAddr;
      dataQ   <= cmdData;
      lenQ    <= cmdLen;
      isStore <= cmdIsStore;
      zeroQ   <= cmdZeroBlk;
      probQ   <= cmdProbState;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= RES_NONE;
      ldDataQ <= '0;
      excQ    <= '0;
    end else begin
      if (ctl.latchCmd) begin
        ldDataQ <= '0;
        excQ    <= '0;
      end
      if (ctl.capExc)  excQ <= portExc;
      if (ctl.capData) ldDataQ <= portLdData;
      if (ctl.setStatus) begin
        statusQ <= ctl.status;
        if (ctl.status != RES_NONE) ldDataQ <= '0;
      end
    end
  end

  assign portAddrValid = reqActive;
  assign portLdReq     = reqActive && !isStore;
  assign portStReq     = reqActive && isStore;
  assign portAddr      = reqActive ? addrQ : '0;
  assign portLen       = reqActive ? lenQ : '0;
  assign portZeroBlk   = reqActive && zeroQ;
  assign portPriv      = reqActive && !probQ;
  assign portStValid   = stStrobe;
  assign portStData    = stStrobe ? dataQ : '0;

  assign resStatus = statusQ;
  assign resLdData = ldDataQ;
  assign resExc    = excQ;

  p_zero_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    (resDone && resStatus != 2'd0) |-> (resLdData == '0));

  p_zero_blk_r12: assert property (@(posedge clk) disable iff (!rstN)
    !portAddrValid |-> !portZeroBlk);

endmodule

// File: rtl/ldst_port_seq.sv
module ldst_port_seq
  import ldst_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int EXC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdIsStore,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [3:0]        cmdLen,
  input  logic              cmdZeroBlk,
  input  logic              cmdProbState,
  output logic              portLdReq,
  output logic              portStReq,
  output logic [ADDR_W-1:0] portAddr,
  output logic              portAddrValid,
  output logic [3:0]        portLen,
  output logic              portZeroBlk,
  output logic              portPriv,
  output logic [DATA_W-1:0] portStData,
  output logic              portStValid,
  input  logic              portAddrOk,
  input  logic              portLdOk,
  input  logic [DATA_W-1:0] portLdData,
  input  logic              portBusy,
  input  logic [EXC_W-1:0]  portExc,
  output logic              resDone,
  output logic [1:0]        resStatus,
  output logic [DATA_W-1:0] resLdData,
  output logic [EXC_W-1:0]  resExc
);

  dpCtl_t ctl;
  logic   reqActive, stStrobe, isStore;

  ldst_seq_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdLen      (cmdLen),
    .isStore     (isStore),
    .portAddrOk  (portAddrOk),
    .portLdOk    (portLdOk),
    .portBusy    (portBusy),
    .excHappened (portExc[EXC_FLAG_BIT]),
    .cmdReady    (cmdReady),
    .reqActive   (reqActive),
    .stStrobe    (stStrobe),
    .resDone     (resDone),
    .ctl         (ctl)
  );

  ldst_seq_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .EXC_W  (EXC_W)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .reqActive     (reqActive),
    .stStrobe      (stStrobe),
    .resDone       (resDone),
    .cmdIsStore    (cmdIsStore),
    .cmdAddr       (cmdAddr),
    .cmdData       (cmdData),
    .cmdLen        (cmdLen),
    .cmdZeroBlk    (cmdZeroBlk),
    .cmdProbState  (cmdProbState),
    .portLdData    (portLdData),
    .portExc       (portExc),
    .isStore       (isStore),
    .portLdReq     (portLdReq),
    .portStReq     (portStReq),
    .portAddr      (portAddr),
    .portAddrValid (portAddrValid),
    .portLen       (portLen),
    .portZeroBlk   (portZeroBlk),
    .portPriv      (portPriv),
    .portStData    (portStData),
    .portStValid   (portStValid),
    .resStatus     (resStatus),
    .resLdData     (resLdData),
    .resExc        (resExc)
  );

  p_priv_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portAddrValid) |-> (portPriv == !$past(cmdProbState)));

  p_priv_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (portAddrValid && $past(portAddrValid)) |-> $stable(portPriv));

endmodule

// File: tb/tb_ldst_port_seq.sv
module tb_ldst_port_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdIsStore = 1'b0, cmdZeroBlk = 1'b0, cmdProbState = 1'b0;
  logic [31:0] cmdAddr = '0;
  logic [63:0] cmdData = '0;
  logic [3:0]  cmdLen = '0;
  logic        portAddrOk = 1'b0, portLdOk = 1'b0, portBusy = 1'b0;
  logic [63:0] portLdData = '0;
  logic [7:0]  portExc = '0;
  logic        cmdReady, portLdReq, portStReq, portAddrValid, portZeroBlk, portPriv, portStValid;
  logic [31:0] portAddr;
  logic [3:0]  portLen;
  logic [63:0] portStData;
  logic        resDone;
  logic [1:0]  resStatus;
  logic [63:0] resLdData;
  logic [7:0]  resExc;

  int checks = 0;
  int failures = 0;

  logic [1:0]  expSt[$];
  logic [7:0]  expEx[$];
  logic [63:0] expDt[$];
  string       expTag[$];

  always #5 clk = ~clk;

  ldst_port_seq dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdIsStore(cmdIsStore), .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdLen(cmdLen),
    .cmdZeroBlk(cmdZeroBlk), .cmdProbState(cmdProbState),
    .portLdReq(portLdReq), .portStReq(portStReq), .portAddr(portAddr),
    .portAddrValid(portAddrValid), .portLen(portLen), .portZeroBlk(portZeroBlk),
    .portPriv(portPriv), .portStData(portStData), .portStValid(portStValid),
    .portAddrOk(portAddrOk), .portLdOk(portLdOk), .portLdData(portLdData),
    .portBusy(portBusy), .portExc(portExc),
    .resDone(resDone), .resStatus(resStatus), .resLdData(resLdData), .resExc(resExc)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected results at each done pulse
  logic prevDone = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (resDone && prevDone) chk(1'b0, "R11 done longer than one cycle", 64'd1, 64'd0);
      if (resDone) begin
        if (expSt.size() == 0) begin
          chk(1'b0, "R11 unexpected done", 64'd1, 64'd0);
        end else begin
          automatic logic [1:0]  s = expSt.pop_front();
          automatic logic [7:0]  e = expEx.pop_front();
          automatic logic [63:0] d = expDt.pop_front();
          automatic string       t = expTag.pop_front();
          chk(resStatus == s, {t, " R11 status"}, 64'(resStatus), 64'(s));
          chk(resExc == e, {t, " R11 exception record"}, 64'(resExc), 64'(e));
          chk(resLdData == d, {t, " R11 load data"}, resLdData, d);
        end
      end
    end
    prevDone <= resDone;
  end

  task automatic pushExp(input logic [1:0] s, input logic [7:0] e, input logic [63:0] d, input string t);
    expSt.push_back(s); expEx.push_back(e); expDt.push_back(d); expTag.push_back(t);
  endtask

  task automatic offer(input bit st, input logic [31:0] a, input logic [63:0] d,
                       input logic [3:0] len, input bit zb, input bit ps);
    @(negedge clk);
    chk(cmdReady == 1'b1, "R1 ready while idle", 64'(cmdReady), 64'd1);
    cmdValid = 1'b1; cmdIsStore = st; cmdAddr = a; cmdData = d;
    cmdLen = len; cmdZeroBlk = zb; cmdProbState = ps;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic checkRaised(input bit st, input logic [31:0] a, input logic [3:0] len,
                             input bit zb, input bit ps);
    chk(portAddrValid && (portStReq == st) && (portLdReq == !st), "R1 request lines raised",
        {61'd0, portAddrValid, portStReq, portLdReq}, {61'd0, 1'b1, st, !st});
    chk(portAddr == a, "R1 address", 64'(portAddr), 64'(a));
    chk(portLen == len, "R1 length", 64'(portLen), 64'(len));
    chk(cmdReady == 1'b0, "R1 not ready while busy", 64'(cmdReady), 64'd0);
    chk(portPriv == !ps, "R3 privilege inverse", 64'(portPriv), 64'(!ps));
    chk(portZeroBlk == zb, "R12 zero-block with request", 64'(portZeroBlk), 64'(zb));
  endtask

  // address phase; returns with action applied at the deciding negedge
  task automatic addrPhase(input int dly, input bit excHere, input logic [7:0] ev);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(portAddrValid == 1'b1, "R4 address still pending", 64'(portAddrValid), 64'd1);
    end
    if (excHere) portExc = ev; else portAddrOk = 1'b1;
  endtask

  task automatic fastTail(input string tag);
    @(negedge clk);
    portExc = '0; portAddrOk = 1'b0;
    chk(portAddrValid && (portStReq || portLdReq), {tag, " R6 held one clock"}, 64'(portAddrValid), 64'd1);
    @(negedge clk);
    chk(!portAddrValid && !portStReq && !portLdReq && !portZeroBlk, {tag, " R6 released"},
        64'(portAddrValid), 64'd0);
  endtask

  // excAt: 0 none, 1 address phase, 2 after strobe, 3 after busy
  task automatic doStore(input logic [31:0] a, input logic [63:0] d, input logic [3:0] len,
                         input bit zb, input bit ps, input int addrDly, input int excAt,
                         input int busyN, input logic [7:0] ev, input string tag);
    int n;
    pushExp(excAt == 0 ? 2'd0 : (excAt == 3 ? 2'd2 : 2'd1), excAt == 0 ? 8'h00 : ev, 64'd0, tag);
    offer(1'b1, a, d, len, zb, ps);
    checkRaised(1'b1, a, len, zb, ps);
    addrPhase(addrDly, excAt == 1, ev);
    if (excAt == 1) begin fastTail({tag, " R4"}); return; end
    @(negedge clk);
    portAddrOk = 1'b0;
    chk(portStValid == 1'b1, {tag, " R5 strobe"}, 64'(portStValid), 64'd1);
    chk(portStData == d, {tag, " R5 store data"}, portStData, d);
    @(negedge clk);
    chk(portStValid == 1'b0, {tag, " R5 strobe one clock"}, 64'(portStValid), 64'd0);
    if (excAt == 2) begin portExc = ev; fastTail(tag); return; end
    portBusy = (busyN > 0);
    n = (busyN > 0) ? busyN : 1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      chk(portStReq == 1'b1, {tag, " R8 request held while busy"}, 64'(portStReq), 64'd1);
      if (k == n) begin
        portBusy = 1'b0;
        if (excAt == 3) portExc = ev;
      end
    end
    if (excAt == 3) begin
      @(negedge clk);
      portExc = '0;
      chk(portStReq == 1'b1, {tag, " R7 slow hold"}, 64'(portStReq), 64'd1);
      @(negedge clk);
      chk(!portStReq && !resDone, {tag, " R7 release then idle"}, {63'd0, portStReq | resDone}, 64'd0);
    end else begin
      @(negedge clk);
      chk(!portStReq && !portAddrValid && !resDone, {tag, " R8 release then idle"},
          {63'd0, portStReq | resDone}, 64'd0);
    end
    @(negedge clk);
    chk(resDone == 1'b1, {tag, " R11 done"}, 64'(resDone), 64'd1);
  endtask

  // excAt: 0 none, 1 address phase, 2 at data return, 3 after busy
  task automatic doLoad(input logic [31:0] a, input logic [3:0] len, input bit ps,
                        input int addrDly, input int excAt, input int ldDly, input int busyN,
                        input logic [63:0] data, input logic [7:0] ev, input string tag);
    int n;
    pushExp(excAt == 0 ? 2'd0 : (excAt == 1 ? 2'd1 : 2'd2), excAt == 0 ? 8'h00 : ev,
            excAt == 0 ? data : 64'd0, tag);
    offer(1'b0, a, 64'hdead, len, 1'b0, ps);
    checkRaised(1'b0, a, len, 1'b0, ps);
    addrPhase(addrDly, excAt == 1, ev);
    if (excAt == 1) begin fastTail({tag, " R4"}); return; end
    @(negedge clk);
    portAddrOk = 1'b0;
    chk(portLdReq == 1'b1, {tag, " R9 gap clock keeps request"}, 64'(portLdReq), 64'd1);
    for (int k = 0; k <= ldDly; k++) begin
      @(negedge clk);
      chk(portLdReq == 1'b1, {tag, " R9 waiting for data"}, 64'(portLdReq), 64'd1);
      if (k == ldDly) begin
        portLdOk = 1'b1; portLdData = data;
        if (excAt == 2) portExc = ev; else portBusy = (busyN > 0);
      end
    end
    @(negedge clk);
    portLdOk = 1'b0; portExc = '0;
    portLdData = 64'hffff_ffff_ffff_ffff;
    chk(!portLdReq && !portAddrValid, {tag, " R10 request drops after capture"},
        64'(portLdReq), 64'd0);
    if (excAt == 2) begin
      chk(resDone == 1'b1, {tag, " R9 slow done"}, 64'(resDone), 64'd1);
      portLdData = '0;
      return;
    end
    n = (busyN > 0) ? busyN : 1;
    for (int k = 1; k <= n; k++) begin
      if (k > 1) @(negedge clk);
      chk(!portAddrValid && !resDone, {tag, " R10 waiting for busy"}, 64'(portAddrValid), 64'd0);
      if (k == n) begin
        portBusy = 1'b0;
        if (excAt == 3) portExc = ev;
      end
    end
    @(negedge clk);
    portExc = '0; portLdData = '0;
    chk(resDone == 1'b1, {tag, " R10 done"}, 64'(resDone), 64'd1);
  endtask

  task automatic doBad(input logic [3:0] len, input string tag);
    pushExp(2'd3, 8'h00, 64'd0, tag);
    offer(1'b1, 32'h40, 64'h1, len, 1'b1, 1'b0);
    chk(!portAddrValid && !portStReq && !portLdReq, {tag, " R2 no request"}, 64'(portAddrValid), 64'd0);
    chk(resDone == 1'b1, {tag, " R2 immediate done"}, 64'(resDone), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmdReady == 1'b1, "R1 reset ready", 64'(cmdReady), 64'd1);
    chk(!portAddrValid && !portLdReq && !portStReq && !portStValid, "R1 reset lines low",
        64'(portAddrValid), 64'd0);
    chk(resDone == 1'b0, "R11 reset no done", 64'(resDone), 64'd0);

    doStore(32'h1000, 64'h1122_3344_5566_7788, 4'd8, 1'b0, 1'b0, 0, 0, 0, 8'h00, "st clean");
    doStore(32'h2008, 64'hab, 4'd1, 1'b1, 1'b1, 2, 0, 3, 8'h00, "st clean busy");
    doStore(32'h3000, 64'h5, 4'd4, 1'b0, 1'b1, 0, 1, 0, 8'h05, "st fast first cycle");
    doStore(32'h3100, 64'h6, 4'd2, 1'b1, 1'b0, 2, 1, 0, 8'h23, "st fast addr wait");
    doStore(32'h3200, 64'h7, 4'd8, 1'b0, 1'b0, 1, 2, 0, 8'h41, "st fast strobe");
    doStore(32'h3300, 64'h8, 4'd4, 1'b1, 1'b1, 0, 3, 2, 8'h81, "st slow");
    doStore(32'h3400, 64'h9, 4'd1, 1'b0, 1'b0, 0, 3, 0, 8'h03, "st slow no busy");
    doLoad(32'h4000, 4'd8, 1'b0, 1, 0, 0, 0, 64'hcafe_f00d_1234_5678, 8'h00, "ld clean");
    doLoad(32'h4100, 4'd2, 1'b1, 0, 0, 3, 2, 64'h0bad_beef, 8'h00, "ld clean waits");
    doLoad(32'h4200, 4'd4, 1'b0, 1, 1, 0, 0, 64'h77, 8'h11, "ld fast addr");
    doLoad(32'h4300, 4'd1, 1'b1, 0, 2, 1, 0, 64'h99, 8'h2b, "ld slow at data");
    doLoad(32'h4400, 4'd8, 1'b0, 2, 3, 0, 1, 64'h55aa, 8'h61, "ld slow at busy");
    doBad(4'd3, "len 3");
    doBad(4'd0, "len 0");
    doStore(32'h5000, 64'h42, 4'd2, 1'b0, 1'b0, 0, 0, 0, 8'h00, "st after bad");

    repeat (3) @(negedge clk);
    chk(expSt.size() == 0, "R11 all results seen", 64'(expSt.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule